// File: doc/BRIEF.md
# Input Capture Event Path

This block is the event side of a single input-capture channel. An asynchronous pin passes through a multi-stage synchronizer and an edge detector. A mode field picks which edges count: both, falling only, rising only, or rising edges divided by one of two prescale ratios. Each qualified event copies the value of an external free-running timebase into a small queue. Software, or a bus wrapper around the block, drains the queue one entry at a time, oldest first, with a pop strobe.

Two flags report the queue state. One shows that an entry is waiting. The other is a sticky flag that records a capture lost to a full queue. A small event counter raises a one-cycle interrupt pulse after a programmable number of qualified events. The timebase counter and any register decoding sit outside the block. Selecting a disabled mode code acts as a clear of all internal state.

Top module: `icap_event_path`

## Requirements
- R1: A pin transition is sampled through two synchronizer flops. A qualifying transition driven before clock edge k is stored on edge k+2, so the queue is still empty after edges k and k+1 and not empty after edge k+2.
- R2: Mode code 3'b001 captures on both edges, 3'b010 only on falling edges and 3'b011 only on rising edges. Edges of the other polarity are ignored.
- R3: Mode code 3'b100 captures on every 4th rising edge and 3'b101 on every 16th rising edge. The first capture comes on the 4th (or 16th) rising edge after the mode is entered, and falling edges do not advance the count.
- R4: Mode codes 3'b000, 3'b110 and 3'b111 are disabled. While disabled, no capture happens. After any cycle spent disabled, the queue is empty, both flags are clear and the prescale and interrupt counts restart from zero.
- R5: Each capture stores the timebase value present on its capture edge. `rd_data` shows the oldest stored entry while the queue is not empty, and entries leave in arrival order. The queue never holds more than 4 entries.
- R6: `buf_not_empty` is high exactly when at least one entry is stored. It is low after reset.
- R7: A capture that meets a full queue (4 entries) is dropped, the stored entries are kept and `buf_overflow` is set. The flag stays set until a pop empties the queue or the block is disabled.
- R8: `cap_irq` pulses for one cycle, one cycle after the Nth qualified event since the last pulse. N is `irq_every`+1 (2'b00 gives 1, 2'b11 gives 4). Dropped captures count as events.
- R9: A pop and a capture on the same edge are both carried out, and the entry count is unchanged.
- R10: A pop while the queue is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_pin | input | 1 | Asynchronous capture input |
| cap_mode | input | 3 | Edge/prescale mode; disabled codes clear the block |
| irq_every | input | 2 | Events per interrupt, minus one |
| timebase | input | 16 | External counter value to capture |
| rd_pop | input | 1 | Remove the oldest entry on this edge |
| rd_data | output | 16 | Oldest stored capture |
| buf_not_empty | output | 1 | At least one entry waiting |
| buf_overflow | output | 1 | Sticky lost-capture flag |
| cap_irq | output | 1 | One-cycle interrupt pulse |

## Verification
The bench aims at the queue boundaries. A fifth capture must be dropped without overwriting the head; a design that wrapped its write pointer would return the newest value first. A pop that lands on the same edge as a capture must neither lose the new entry nor double-count it. The overflow flag must survive partial draining and clear only on the last pop. The bench also checks the prescaler phase after a disable, where a stale count would fire early, and the exact two-flop latency of the synchronizer. Random edge, pop, mode and threshold traffic is then checked against a reference queue model kept in the bench.

// File: rtl/icap_pkg.sv
package icap_pkg;

   typedef enum logic [2:0] {
      ICM_OFF       = 3'b000,
      ICM_BOTH      = 3'b001,
      ICM_FALL      = 3'b010,
      ICM_RISE      = 3'b011,
      ICM_RISE_DIVA = 3'b100,
      ICM_RISE_DIVB = 3'b101
   } icap_mode_e;

   function automatic logic icap_mode_active(input logic [2:0] code);
      return (code >= 3'b001) && (code <= 3'b101);
   endfunction

endpackage

// File: rtl/icap_sync_edge.sv
module icap_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_async,
   output logic rise,
   output logic fall
);

   logic [STAGES-1:0] chain;
   logic              last_q;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= pin_async;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[i] <= 1'b0;
               else        chain[i] <= chain[i-1];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= chain[STAGES-1];

   assign rise = chain[STAGES-1] & ~last_q;
   assign fall = ~chain[STAGES-1] & last_q;

endmodule

// File: rtl/icap_prescale.sv
module icap_prescale
   import icap_pkg::*;
#(
   parameter int DIV_A = 4,
   parameter int DIV_B = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       enable,
   input  icap_mode_e mode,
   input  logic       rise,
   input  logic       fall,
   output logic       fire
);

   localparam int DIV_MAX = (DIV_A > DIV_B) ? DIV_A : DIV_B;
   localparam int CW      = $clog2(DIV_MAX);

   logic          edge_hit;
   logic          use_div;
   logic [CW-1:0] limit;
   logic [CW-1:0] cnt;

   always_comb begin
      edge_hit = 1'b0;
      use_div  = 1'b0;
      limit    = '0;
      unique case (mode)
         ICM_BOTH:      edge_hit = rise | fall;
         ICM_FALL:      edge_hit = fall;
         ICM_RISE:      edge_hit = rise;
         ICM_RISE_DIVA: begin
            edge_hit = rise;
            use_div  = 1'b1;
            limit    = CW'(DIV_A - 1);
         end
         ICM_RISE_DIVB: begin
            edge_hit = rise;
            use_div  = 1'b1;
            limit    = CW'(DIV_B - 1);
         end
         default: edge_hit = 1'b0;
      endcase
   end

   assign fire = enable && edge_hit && (!use_div || (cnt == limit));

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                   cnt <= '0;
      else if (!enable)             cnt <= '0;
      else if (edge_hit && use_div) cnt <= (cnt == limit) ? '0 : cnt + 1'b1;

endmodule

// File: rtl/icap_fifo.sv
module icap_fifo #(
   parameter int W     = 16,
   parameter int DEPTH = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         clr,
   input  logic                         push,
   input  logic [W-1:0]                 push_data,
   input  logic                         pop,
   output logic [W-1:0]                 head,
   output logic [$clog2(DEPTH+1)-1:0]   count,
   output logic                         overflow
);

   localparam int PW   = $clog2(DEPTH);
   localparam int CNTW = $clog2(DEPTH + 1);

   logic [W-1:0]    mem [DEPTH];
   logic [PW-1:0]   wr_ptr, rd_ptr;
   logic            full, empty, do_push, do_pop;
   logic [CNTW-1:0] count_nxt;

   assign full      = (count == CNTW'(DEPTH));
   assign empty     = (count == '0);
   assign do_push   = push && !full;
   assign do_pop    = pop && !empty;
   assign count_nxt = count + CNTW'(do_push) - CNTW'(do_pop);

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_slot
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n)
               mem[i] <= '0;
            else if (do_push && !clr && (wr_ptr == PW'(i)))
               mem[i] <= push_data;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         wr_ptr   <= '0;
         rd_ptr   <= '0;
         count    <= '0;
         overflow <= 1'b0;
      end else if (clr) begin
         wr_ptr   <= '0;
         rd_ptr   <= '0;
         count    <= '0;
         overflow <= 1'b0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + 1'b1;
         if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
         count <= count_nxt;
         if (push && full)           overflow <= 1'b1;
         else if (count_nxt == '0)   overflow <= 1'b0;
      end

   assign head = mem[rd_ptr];

endmodule

// File: rtl/icap_event_path.sv
module icap_event_path
   import icap_pkg::*;
#(
   parameter int TS_W        = 16,
   parameter int FIFO_DEPTH  = 4,
   parameter int SYNC_STAGES = 2,
   parameter int PRESCALE_A  = 4,
   parameter int PRESCALE_B  = 16,
   parameter int THRESH_W    = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cap_pin,
   input  logic [2:0]          cap_mode,
   input  logic [THRESH_W-1:0] irq_every,
   input  logic [TS_W-1:0]     timebase,
   input  logic                rd_pop,
   output logic [TS_W-1:0]     rd_data,
   output logic                buf_not_empty,
   output logic                buf_overflow,
   output logic                cap_irq
);

   localparam int CNTW = $clog2(FIFO_DEPTH + 1);

   if (FIFO_DEPTH < 2 || (FIFO_DEPTH & (FIFO_DEPTH - 1)) != 0) begin : g_bad_depth
      $error("FIFO_DEPTH must be a power of two of at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (PRESCALE_A < 2 || PRESCALE_B < 2) begin : g_bad_div
      $error("prescale ratios must be at least 2");
   end
   if (TS_W < 1 || THRESH_W < 1) begin : g_bad_width
      $error("widths must be positive");
   end

   logic                mode_en;
   icap_mode_e          mode;
   logic                rise, fall;
   logic                cap_evt;
   logic [CNTW-1:0]     fifo_count;
   logic [THRESH_W-1:0] irq_cnt;
   logic                irq_q;

   assign mode    = icap_mode_e'(cap_mode);
   assign mode_en = icap_mode_active(cap_mode);

   icap_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_async (cap_pin),
      .rise      (rise),
      .fall      (fall)
   );

   icap_prescale #(.DIV_A(PRESCALE_A), .DIV_B(PRESCALE_B)) u_pre (
      .clk    (clk),
      .rst_n  (rst_n),
      .enable (mode_en),
      .mode   (mode),
      .rise   (rise),
      .fall   (fall),
      .fire   (cap_evt)
   );

   icap_fifo #(.W(TS_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (!mode_en),
      .push      (cap_evt),
      .push_data (timebase),
      .pop       (rd_pop),
      .head      (rd_data),
      .count     (fifo_count),
      .overflow  (buf_overflow)
   );

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         irq_cnt <= '0;
         irq_q   <= 1'b0;
      end else if (!mode_en) begin
         irq_cnt <= '0;
         irq_q   <= 1'b0;
      end else begin
         irq_q <= 1'b0;
         if (cap_evt) begin
            if (irq_cnt == irq_every) begin
               irq_cnt <= '0;
               irq_q   <= 1'b1;
            end else begin
               irq_cnt <= irq_cnt + 1'b1;
            end
         end
      end

   assign buf_not_empty = (fifo_count != '0);
   assign cap_irq       = irq_q;

endmodule

// File: rtl/icap_event_path_chk.sv
module icap_event_path_chk #(
   parameter int DEPTH = 4,
   parameter int CNTW  = 3
) (
   input logic            clk,
   input logic            rst_n,
   input logic            mode_en,
   input logic            cap_evt,
   input logic            pop,
   input logic [CNTW-1:0] count,
   input logic            overflow,
   input logic            irq
);

   p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNTW'(DEPTH));

   p_evt_enabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cap_evt |-> mode_en);

   p_disabled_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_en |=> (count == '0 && !overflow && !irq));

   p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overflow) |-> $past(cap_evt && count == CNTW'(DEPTH)));

   p_ovf_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(overflow) |-> (count == '0));

   p_irq_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(cap_evt));

   p_pushpop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_evt && pop && count != '0 && count != CNTW'(DEPTH)) |=> $stable(count));

   p_pop_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && count == '0 && !cap_evt) |=> (count == '0));

endmodule

bind icap_event_path icap_event_path_chk #(
   .DEPTH (FIFO_DEPTH),
   .CNTW  (CNTW)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .mode_en  (mode_en),
   .cap_evt  (cap_evt),
   .pop      (rd_pop),
   .count    (fifo_count),
   .overflow (buf_overflow),
   .irq      (cap_irq)
);

// File: tb/icap_event_path_bench.sv
`timescale 1ns/1ps
module icap_event_path_bench;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cap_pin;
   logic [2:0]  cap_mode;
   logic [1:0]  irq_every;
   logic [15:0] timebase;
   logic        rd_pop;
   logic [15:0] rd_data;
   logic        buf_not_empty;
   logic        buf_overflow;
   logic        cap_irq;

   always #2 clk = ~clk;

   icap_event_path u_icap_event_path (
      .clk           (clk),
      .rst_n         (rst_n),
      .cap_pin       (cap_pin),
      .cap_mode      (cap_mode),
      .irq_every     (irq_every),
      .timebase      (timebase),
      .rd_pop        (rd_pop),
      .rd_data       (rd_data),
      .buf_not_empty (buf_not_empty),
      .buf_overflow  (buf_overflow),
      .cap_irq       (cap_irq)
   );

   int checks = 0;
   int errors = 0;
   logic [15:0] q_m[$];
   bit  ovf_m;
   bit  pin_m;
   int  pcnt_m, icnt_m, irq_exp, irq_seen;
   bit  done = 1'b0;

   always @(negedge clk) if (rst_n && cap_irq) irq_seen++;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic bit mode_on(input logic [2:0] m);
      return (m >= 3'd1) && (m <= 3'd5);
   endfunction

   function automatic bit edge_counts(input logic [2:0] m, input bit r, input bit f);
      case (m)
         3'd1:             return r | f;
         3'd2:             return f;
         3'd3, 3'd4, 3'd5: return r;
         default:          return 1'b0;
      endcase
   endfunction

   function automatic int div_of(input logic [2:0] m);
      return (m == 3'd4) ? 4 : (m == 3'd5) ? 16 : 1;
   endfunction

   task automatic model_event(input bit r, input bit f);
      bit fire = 1'b0;
      if (mode_on(cap_mode) && edge_counts(cap_mode, r, f)) begin
         if (div_of(cap_mode) == 1) fire = 1'b1;
         else if (pcnt_m == div_of(cap_mode) - 1) begin
            pcnt_m = 0;
            fire = 1'b1;
         end else pcnt_m++;
      end
      if (fire) begin
         if (q_m.size() < 4) q_m.push_back(timebase);
         else ovf_m = 1'b1;
         if (icnt_m == int'(irq_every)) begin
            icnt_m = 0;
            irq_exp++;
         end else icnt_m++;
      end
   endtask

   task automatic drive_pin(input bit v, input logic [15:0] tb);
      bit r, f;
      timebase = tb;
      cap_pin  = v;
      r = v & ~pin_m;
      f = ~v & pin_m;
      pin_m = v;
      repeat (4) @(negedge clk);
      model_event(r, f);
   endtask

   task automatic do_pop();
      if (q_m.size() > 0)
         chk(rd_data == q_m[0], "R5 head order", int'(rd_data), int'(q_m[0]));
      rd_pop = 1'b1;
      @(negedge clk);
      rd_pop = 1'b0;
      if (q_m.size() > 0) begin
         void'(q_m.pop_front());
         if (q_m.size() == 0) ovf_m = 1'b0;
      end
   endtask

   task automatic set_mode(input logic [2:0] m);
      cap_mode = 3'd0;
      @(negedge clk);
      q_m.delete();
      ovf_m  = 1'b0;
      pcnt_m = 0;
      icnt_m = 0;
      cap_mode = m;
      @(negedge clk);
   endtask

   task automatic check_state(input string req);
      chk(buf_not_empty == (q_m.size() != 0), {req, " R6 not-empty"},
          int'(buf_not_empty), int'(q_m.size() != 0));
      chk(buf_overflow == ovf_m, {req, " R7 overflow"}, int'(buf_overflow), int'(ovf_m));
      chk(irq_seen == irq_exp, {req, " R8 irq count"}, irq_seen, irq_exp);
   endtask

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual hung expected finish");
         summary();
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1729));
      rst_n = 1'b0; cap_pin = 1'b0; cap_mode = 3'd0; irq_every = 2'd0;
      timebase = 16'd0; rd_pop = 1'b0;
      pin_m = 1'b0; ovf_m = 1'b0; pcnt_m = 0; icnt_m = 0; irq_exp = 0; irq_seen = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!buf_not_empty && !buf_overflow && !cap_irq, "R6 reset state",
          int'({buf_not_empty, buf_overflow, cap_irq}), 0);

      // R4: disabled codes ignore edges
      drive_pin(1'b1, 16'h0A0A);
      drive_pin(1'b0, 16'h0B0B);
      chk(!buf_not_empty, "R4 mode 000 ignores edges", int'(buf_not_empty), 0);
      set_mode(3'd6);
      drive_pin(1'b1, 16'h0C0C);
      drive_pin(1'b0, 16'h0D0D);
      chk(!buf_not_empty, "R4 mode 110 ignores edges", int'(buf_not_empty), 0);
      set_mode(3'd7);
      drive_pin(1'b1, 16'h0E0E);
      check_state("R4 mode 111");

      // R1: exact two-flop latency
      set_mode(3'd3);
      drive_pin(1'b0, 16'h0000);
      timebase = 16'h1111;
      cap_pin  = 1'b1;
      @(negedge clk);
      chk(!buf_not_empty, "R1 empty after first edge", int'(buf_not_empty), 0);
      @(negedge clk);
      chk(!buf_not_empty, "R1 empty after second edge", int'(buf_not_empty), 0);
      @(negedge clk);
      chk(buf_not_empty, "R1 stored on third edge", int'(buf_not_empty), 1);
      @(negedge clk);
      pin_m = 1'b1;
      model_event(1'b1, 1'b0);
      check_state("R1");
      chk(rd_data == 16'h1111, "R5 captured timebase", int'(rd_data), 16'h1111);
      do_pop();

      // R2: polarity selection
      drive_pin(1'b0, 16'h2001);
      check_state("R2 rising mode ignores fall");
      set_mode(3'd2);
      drive_pin(1'b1, 16'h2002);
      check_state("R2 falling mode ignores rise");
      drive_pin(1'b0, 16'h2003);
      check_state("R2 falling mode capture");
      do_pop();
      set_mode(3'd1);
      drive_pin(1'b1, 16'h2004);
      drive_pin(1'b0, 16'h2005);
      check_state("R2 both edges");
      do_pop();
      do_pop();

      // R3: prescaled rising edges
      set_mode(3'd4);
      for (int i = 0; i < 3; i++) begin
         drive_pin(1'b1, 16'h3000 + 16'(i));
         drive_pin(1'b0, 16'h3100);
      end
      chk(!buf_not_empty, "R3 no capture before 4th rise", int'(buf_not_empty), 0);
      drive_pin(1'b1, 16'h3004);
      drive_pin(1'b0, 16'h3104);
      check_state("R3 div4");
      do_pop();
      set_mode(3'd5);
      for (int i = 0; i < 16; i++) begin
         drive_pin(1'b1, 16'h3200 + 16'(i));
         drive_pin(1'b0, 16'h3300);
         if (i == 14)
            chk(!buf_not_empty, "R3 no capture before 16th rise", int'(buf_not_empty), 0);
      end
      check_state("R3 div16");
      do_pop();

      // R7: overflow keeps entries and is sticky
      set_mode(3'd1);
      for (int i = 0; i < 6; i++) drive_pin(~pin_m, 16'h7000 + 16'(i));
      check_state("R7 full plus two");
      for (int i = 0; i < 3; i++) begin
         do_pop();
         check_state("R7 partial drain");
      end
      do_pop();
      check_state("R7 drained");
      for (int i = 0; i < 5; i++) drive_pin(~pin_m, 16'h7100 + 16'(i));
      check_state("R7 set again");
      set_mode(3'd1);
      check_state("R4 disable clears overflow");

      // R8: interrupt thresholds
      for (int t = 0; t < 4; t++) begin
         irq_every = 2'(t);
         set_mode(3'd1);
         for (int i = 0; i < 9; i++) drive_pin(~pin_m, 16'h8000 + 16'(i));
         check_state("R8 threshold");
      end
      irq_every = 2'd0;

      // R9: pop and capture on the same edge
      set_mode(3'd1);
      drive_pin(~pin_m, 16'h9001);
      drive_pin(~pin_m, 16'h9002);
      timebase = 16'h9003;
      cap_pin  = ~pin_m;
      pin_m    = ~pin_m;
      @(negedge clk);
      @(negedge clk);
      rd_pop = 1'b1;
      chk(rd_data == 16'h9001, "R9 head before pop", int'(rd_data), 16'h9001);
      @(negedge clk);
      rd_pop = 1'b0;
      void'(q_m.pop_front());
      model_event(1'b1, 1'b0);
      @(negedge clk);
      check_state("R9");
      do_pop();
      do_pop();
      check_state("R9 drained");

      // R10: pop on empty queue
      do_pop();
      drive_pin(~pin_m, 16'hA001);
      chk(rd_data == 16'hA001, "R10 empty pop left state intact", int'(rd_data), 16'hA001);
      do_pop();
      check_state("R10");

      // random traffic
      for (int n = 0; n < 600; n++) begin
         int op = $urandom_range(0, 99);
         if (op < 55)      drive_pin(~pin_m, 16'($urandom_range(0, 65535)));
         else if (op < 85) do_pop();
         else if (op < 92) set_mode(3'($urandom_range(0, 7)));
         else              irq_every = 2'($urandom_range(0, 3));
         if (n % 25 == 0) check_state("random R5 R7 R8");
      end
      check_state("random final");

      done = 1'b1;
      summary();
      $finish;
   end

endmodule